// File: doc/BRIEF.md
# Seconds-Match Time-of-Day Alarm

This block raises a one-shot alarm when a free-running seconds count reaches a programmed value. Software loads a 20-bit alarm time through two write strobes: one for the low half-word and one for the top nibble. It then sets the enable. The compare runs only on the cycle where the sub-second prescaler signals that a new second has begun. Upper bits of the seconds count above the compared window take no part.

A hit latches a sticky flag that holds until software clears it. The flag drives an interrupt request, which is gated by a local enable and a system-wide enable. The same gated request doubles as a wakeup from a stopped state. With 20 compared bits, an alarm can be placed from 1 second up to roughly 12 days ahead at 1-second resolution.

Top module: `tod_alarm`

## Requirements
- R1: After reset the flag, interrupt request and wakeup request are 0, and the stored alarm value is all zeros.
- R2: A write on `wr_lo` loads `wr_data[15:0]` into alarm bits 15:0. A write on `wr_hi` loads `wr_data[3:0]` into alarm bits 19:16, and `wr_data[15:4]` is discarded.
- R3: While `alarm_en` is 1, both write strobes are ignored and the stored alarm value is unchanged.
- R4: Only bits 19:0 of `sec_count` are compared; bits above 19 have no effect on the match.
- R5: On a clock edge where `rollover`, `alarm_en` and a match are all 1, the flag is 1 from the following cycle.
- R6: A match without `rollover` does not set the flag.
- R7: With `alarm_en` at 0, a rollover with a matching count does not set the flag.
- R8: Once set, the flag stays 1 across later rollovers and non-matches until a cycle with `flag_clr` at 1 clears it.
- R9: When `flag_clr` and a qualified match occur on the same edge, the flag ends up 1.
- R10: `irq_req` is 1 exactly when the flag, `irq_en` and `global_ie` are all 1, and `wake_req` equals `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo | input | 1 | Write strobe for alarm bits 15:0 |
| wr_hi | input | 1 | Write strobe for alarm bits 19:16 |
| wr_data | input | 16 | Write data |
| alarm_en | input | 1 | Alarm enable; also locks the alarm value |
| irq_en | input | 1 | Alarm interrupt enable |
| global_ie | input | 1 | System-level interrupt enable |
| sec_count | input | 32 | Free-running seconds count |
| rollover | input | 1 | One-cycle strobe at the start of each second |
| flag_clr | input | 1 | Clears the sticky flag (software write of 0) |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_req | output | 1 | Gated interrupt request |
| wake_req | output | 1 | Wakeup request from stop |

## Verification
The bench uses the default parameters: a 32-bit seconds count, a 20-bit compare window and a 16-bit low half. This puts the full 12-bit span above the window within reach, so counts such as 0xABC51234 must still hit on 0x51234. The nibble split is exercised with junk in the discarded upper write bits. The 0xFFFFF corner is covered, as is a clear that lands on the same edge as a qualified hit.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int unsigned DEF_SEC_W   = 32;
  localparam int unsigned DEF_MATCH_W = 20;
  localparam int unsigned DEF_LO_W    = 16;

  function automatic logic window_equal(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input int unsigned w);
    logic eq;
    eq = 1'b1;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < w && a[i] != b[i]) eq = 1'b0;
    end
    return eq;
  endfunction
endpackage

// File: rtl/alarm_value_reg.sv
module alarm_value_reg #(
  parameter int unsigned MATCH_W = 20,
  parameter int unsigned LO_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [LO_W-1:0]    wr_data,
  output logic [MATCH_W-1:0] value
);
  localparam int unsigned HI_W = MATCH_W - LO_W;

  logic [MATCH_W-1:0] val_q, val_d;
  logic               ld_lo, ld_hi;

  assign ld_lo = wr_lo && !lock;
  assign ld_hi = wr_hi && !lock;

  always_comb begin
    val_d = val_q;
    if (ld_lo) val_d[LO_W-1:0] = wr_data;
  end

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (ld_hi) hi_q <= wr_data[HI_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val_q[LO_W-1:0] <= '0;
        else if (ld_lo) val_q[LO_W-1:0] <= val_d[LO_W-1:0];
      end
      always_comb val_q[MATCH_W-1:LO_W] = hi_q;
    end else begin : g_lo_only
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val_q <= '0;
        else if (ld_lo) val_q <= val_d;
      end
    end
  endgenerate

  assign value = val_q;

  a_r3_value_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(val_q));
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import tod_alarm_pkg::*;
#(
  parameter int unsigned SEC_W   = 32,
  parameter int unsigned MATCH_W = 20
) (
  input  logic [SEC_W-1:0]   sec_count,
  input  logic [MATCH_W-1:0] value,
  input  logic               rollover,
  input  logic               enable,
  output logic               hit
);
  logic [MATCH_W-1:0] window;

  assign window = sec_count[MATCH_W-1:0];
  assign hit    = rollover && enable && (window == value);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !flag_q) |=> !flag_q);
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
#(
  parameter int unsigned SEC_W   = DEF_SEC_W,
  parameter int unsigned MATCH_W = DEF_MATCH_W,
  parameter int unsigned LO_W    = DEF_LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [LO_W-1:0]  wr_data,
  input  logic             alarm_en,
  input  logic             irq_en,
  input  logic             global_ie,
  input  logic [SEC_W-1:0] sec_count,
  input  logic             rollover,
  input  logic             flag_clr,
  output logic             alarm_flag,
  output logic             irq_req,
  output logic             wake_req
);
  logic [MATCH_W-1:0] alarm_val;
  logic               hit;

  alarm_value_reg #(.MATCH_W(MATCH_W), .LO_W(LO_W)) u_value (
    .clk(clk), .rst_n(rst_n), .lock(alarm_en),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .value(alarm_val)
  );

  alarm_match #(.SEC_W(SEC_W), .MATCH_W(MATCH_W)) u_match (
    .sec_count(sec_count), .value(alarm_val), .rollover(rollover),
    .enable(alarm_en), .hit(hit)
  );

  alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(flag_clr), .flag(alarm_flag)
  );

  assign irq_req  = alarm_flag && irq_en && global_ie;
  assign wake_req = irq_req;

  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && alarm_en &&
     window_equal(64'(sec_count), 64'(alarm_val), MATCH_W)) |=> alarm_flag);
  a_r10_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> alarm_flag);
endmodule

// File: tb/test_tod_alarm.sv
module test_tod_alarm;
  logic        clk, rst_n;
  logic        wr_lo, wr_hi, alarm_en, irq_en, global_ie, rollover, flag_clr;
  logic [15:0] wr_data;
  logic [31:0] sec_count;
  logic        alarm_flag, irq_req, wake_req;

  int n_cmp, n_bad;
  logic [19:0] m_val;
  logic        m_flag;
  logic [2:0]  exp_q[$];
  int          req_q[$];

  tod_alarm i_tod_alarm (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .alarm_en(alarm_en), .irq_en(irq_en), .global_ie(global_ie),
    .sec_count(sec_count), .rollover(rollover), .flag_clr(flag_clr),
    .alarm_flag(alarm_flag), .irq_req(irq_req), .wake_req(wake_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input logic wl, input logic wh, input logic [15:0] d,
                      input logic en, input logic ie, input logic gie,
                      input logic [31:0] sec, input logic roll,
                      input logic clr, input int req);
    logic set, irq;
    @(negedge clk);
    wr_lo = wl; wr_hi = wh; wr_data = d; alarm_en = en; irq_en = ie;
    global_ie = gie; sec_count = sec; rollover = roll; flag_clr = clr;
    set = roll && en && (sec[19:0] == m_val);
    m_flag = set || (m_flag && !clr);
    if (!en && wl) m_val[15:0]  = d;
    if (!en && wh) m_val[19:16] = d[3:0];
    irq = m_flag && ie && gie;
    exp_q.push_back({m_flag, irq, irq});
    req_q.push_back(req);
    @(posedge clk);
  endtask

  initial begin : monitor
    logic [2:0] e;
    int r;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        n_cmp++;
        if ({alarm_flag, irq_req, wake_req} !== e) begin
          n_bad++;
          $display("FAIL R%0d: flag/irq/wake actual %b expected %b", r,
                   {alarm_flag, irq_req, wake_req}, e);
        end
      end
    end
  end

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0; m_val = '0; m_flag = 1'b0;
    rst_n = 1'b0; wr_lo = 0; wr_hi = 0; wr_data = '0; alarm_en = 0;
    irq_en = 0; global_ie = 0; sec_count = '0; rollover = 0; flag_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_cmp++; // R1 reset outputs
    if ({alarm_flag, irq_req, wake_req} !== 3'b000) begin
      n_bad++;
      $display("FAIL R1: actual %b expected 000", {alarm_flag, irq_req, wake_req});
    end
    // R1: reset value 0 matches low window of 0x100000 (R4 upper bits)
    step(0,0,16'h0,1,1,1,32'h0010_0000,1,0, 1);
    step(0,0,16'h0,1,1,1,32'h0010_0001,1,1, 8);
    // R2: load 0x51234 with junk in upper write bits
    step(1,0,16'h1234,0,0,0,32'h0,0,0, 2);
    step(0,1,16'hFFF5,0,0,0,32'h0,0,0, 2);
    // R6: match without rollover
    step(0,0,16'h0,1,1,1,32'h0005_1234,0,0, 6);
    step(0,0,16'h0,1,1,1,32'h0005_1233,1,0, 5);
    // R4/R5: upper bits differ, still hits
    step(0,0,16'h0,1,0,0,32'hABC5_1234,1,0, 4);
    // R10 gating combinations
    step(0,0,16'h0,1,1,0,32'hABC5_1235,1,0, 10);
    step(0,0,16'h0,1,0,1,32'hABC5_1236,1,0, 10);
    step(0,0,16'h0,1,1,1,32'hABC5_1237,1,0, 10);
    // R8 sticky then clear
    repeat (3) step(0,0,16'h0,1,1,1,32'h0,0,0, 8);
    step(0,0,16'h0,1,1,1,32'h0,0,1, 8);
    step(0,0,16'h0,1,1,1,32'h0,0,0, 8);
    // R7: disabled, match with rollover
    step(0,0,16'h0,0,1,1,32'h0005_1234,1,0, 7);
    step(0,0,16'h0,0,1,1,32'h0005_1234,0,0, 7);
    // R3: writes while enabled ignored
    step(1,0,16'h0000,1,1,1,32'h0,0,0, 3);
    step(0,1,16'h0009,1,1,1,32'h0,0,0, 3);
    step(0,0,16'h0,1,1,1,32'h0009_0000,1,0, 3);
    step(0,0,16'h0,1,1,1,32'h0005_1234,1,0, 3);
    // R9: clear and qualified hit on the same edge
    step(0,0,16'h0,1,1,1,32'h0005_1234,1,1, 9);
    step(0,0,16'h0,1,1,1,32'h0,0,1, 9);
    // R2 high nibble only, then boundary value 0xFFFFF
    step(0,1,16'h000A,0,1,1,32'h0,0,0, 2);
    step(0,0,16'h0,1,1,1,32'h0005_1234,1,0, 2);
    step(0,0,16'h0,1,1,1,32'h000A_1234,1,0, 2);
    step(0,0,16'h0,0,1,1,32'h0,0,1, 8);
    step(1,1,16'hFFFF,0,1,1,32'h0,0,0, 2);
    step(0,0,16'h0,1,1,1,32'h000F_FFFE,1,0, 4);
    step(0,0,16'h0,1,1,1,32'hFFFF_FFFF,1,0, 4);
    repeat (3) @(posedge clk);
    #1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule